// File: doc/BRIEF.md
# Programmable Video Line Delay Store

This block holds the line delays that a two-dimensional image filter needs to see vertically adjacent pixels at the same moment. Every clock one pixel enters. Each delay stage returns the pixel that entered that stage exactly one programmed line length earlier. The storage is one memory split into eight equal banks. The banks serve as four long lines, as eight short lines, or as four lines of 16-bit pixels built from both byte inputs. The stages form two equal groups. The second group either continues the chain of the first or takes its own pixel stream, which allows processing of interlaced fields or of two frames at once.

A shared address pointer sweeps every line. It is forced to zero, and memory writes stop, while the line-reset input is high. The first stage can be skipped so that tap 0 carries the live pixel. The second byte port can be turned around to present the last stage's output. A copy of line reset leaves the block after a programmable number of clocks.

Top module: `ldly_store`

## Requirements
- R1: With a programmed length L, every clock one pixel is taken in; the first stage output (tap 0, bypass low) shows a pixel in the clock that comes exactly L clocks after it was presented, the shared pointer stepping by one and wrapping from L-1 to 0.
- R2: A length of 0, or one above the mode maximum, acts as the mode maximum: LINE_MAX with four 8-bit lines, LINE_MAX/2 with eight lines or 16-bit pixels.
- R3: Config word bit 0 = 0 and bit 1 = 0 selects four 8-bit lines: tap k (bits 16k+15..16k of taps_o) is the input delayed (k+1)*L with its upper byte 0, and taps 4 to 7 read 0.
- R4: Config bit 0 = 1 with bit 1 = 0 selects eight lines; all eight taps are active.
- R5: Config bit 2 = 1 chains the groups (first stage of the second group, line 2 with four lines or line 4 with eight, fed by the last tap of the first group); bit 2 = 0 feeds that stage from pix_b_i, so tap (half+j) shows pix_b_i delayed (j+1)*L.
- R6: With bypass_i high, tap 0 shows the current pixel input with no delay and tap k shows it delayed k*L.
- R7: While lres_i is high the pointer stays at 0 and no line is written, so taps 1 and up stay unchanged; after lres_i falls, the first pixel is stored at address 0.
- R8: lres_dly_o equals lres_i as it was dly_i clocks earlier; dly_i = 0 passes it in the same cycle.
- R9: Config bit 3 = 1 with bit 1 = 0 sets pix_b_oe to 1, puts the low byte of the last active tap on pix_b_o and forces the groups into a chain; otherwise pix_b_oe and pix_b_o are 0.
- R10: Config bit 1 = 1 selects 16-bit pixels {pix_a_i, pix_b_i} (high byte from pix_a_i) through four chained lines of maximum length LINE_MAX/2; tap k carries the full 16-bit pixel delayed (k+1)*L, and bits 0 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 4 | Mode word: bit 0 eight lines, bit 1 16-bit pixels, bit 2 chained groups, bit 3 last stage on port B |
| len_i | input | clog2(LINE_MAX)+1 | Programmed line length |
| dly_i | input | DLY_W | Clocks of delay for the line-reset copy |
| bypass_i | input | 1 | Skip the first stage of the first group |
| lres_i | input | 1 | Line reset: holds the pointer at zero and stops writes |
| pix_a_i | input | PIX_W | Pixel into the first group (high byte in 16-bit mode) |
| pix_b_i | input | PIX_W | Pixel into the second group (low byte in 16-bit mode) |
| taps_o | output | NLINE*2*PIX_W | All stage outputs, 2*PIX_W bits per tap, tap 0 lowest |
| pix_b_o | output | PIX_W | Last stage low byte when port B is turned around |
| pix_b_oe | output | 1 | Port B drive enable |
| lres_dly_o | output | 1 | Delayed copy of lres_i |

## Verification
The memory is read combinationally at the pointer, so tap k is due (k+1)*L clocks after its pixel is presented, k*L with bypass, and (j+1)*L on the second group's j-th stage when it is fed separately. The delayed line reset is due exactly dly_i clocks later. When it drives a pixel, the driver works out the due cycle of every affected tap and of the reset copy and queues the expected value with that cycle. The monitor compares an entry only in the cycle named in it, a little after the falling edge, and only entries that fall inside the current mode phase are queued. Held taps during line reset are compared against a snapshot taken one cycle after reset rises, when the pointer has settled at zero.

// File: rtl/ldly_pkg.sv
package ldly_pkg;
   // Mode word layout (bit 3 down to bit 0)
   typedef struct packed {
      logic port_b_out;   // bit 3: last stage presented on port B
      logic chained;      // bit 2: second group fed from first group
      logic wide;         // bit 1: 16-bit pixels
      logic eight;        // bit 0: eight short lines
   } ldly_cfg_t;

   function automatic logic eight_active(input ldly_cfg_t c);
      return c.eight & ~c.wide;
   endfunction

   function automatic logic port_b_active(input ldly_cfg_t c);
      return c.port_b_out & ~c.wide;
   endfunction
endpackage

// File: rtl/ldly_addr_gen.sv
module ldly_addr_gen #(
   parameter int PTR_W = 6,
   parameter int LEN_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic [LEN_W-1:0] eff_len_i,
   output logic [PTR_W-1:0] ptr_o
);
   logic [LEN_W-1:0] last_w;
   assign last_w = eff_len_i - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_o <= '0;
      else if (hold_i)
         ptr_o <= '0;
      else if ({1'b0, ptr_o} >= last_w)
         ptr_o <= '0;
      else
         ptr_o <= ptr_o + 1'b1;
   end
endmodule

// File: rtl/ldly_bank.sv
module ldly_bank #(
   parameter int DEPTH = 32,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [W-1:0]  wdata_i,
   output logic [W-1:0]  rdata_o
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[addr_i] <= wdata_i;
   end

   // read before the write lands: old contents at this address
   assign rdata_o = mem[addr_i];
endmodule

// File: rtl/ldly_rst_delay.sv
module ldly_rst_delay #(
   parameter int DLY_W = 6,
   localparam int SR_LEN = (1 << DLY_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             q_o
);
   logic [SR_LEN-1:0] sr;
   logic [DLY_W-1:0]  sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[SR_LEN-2:0], d_i};
   end

   assign sel = dly_i - 1'b1;
   assign q_o = (dly_i == '0) ? d_i : sr[sel];
endmodule

// File: rtl/ldly_store.sv
module ldly_store
   import ldly_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int LINE_MAX = 64,
   parameter int NLINE    = 8,
   parameter int DLY_W    = 6,
   localparam int PTR_W   = $clog2(LINE_MAX),
   localparam int LEN_W   = PTR_W + 1,
   localparam int TAP_W   = 2 * PIX_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [3:0]             cfg_i,
   input  logic [LEN_W-1:0]       len_i,
   input  logic [DLY_W-1:0]       dly_i,
   input  logic                   bypass_i,
   input  logic                   lres_i,
   input  logic [PIX_W-1:0]       pix_a_i,
   input  logic [PIX_W-1:0]       pix_b_i,
   output logic [NLINE*TAP_W-1:0] taps_o,
   output logic [PIX_W-1:0]       pix_b_o,
   output logic                   pix_b_oe,
   output logic                   lres_dly_o
);
   localparam int NHALF      = NLINE / 2;
   localparam int BANK_DEPTH = LINE_MAX / 2;
   localparam int BAW        = $clog2(BANK_DEPTH);

   // elaboration-time parameter checks
   if (LINE_MAX < 4 || (LINE_MAX & (LINE_MAX - 1)) != 0) begin : g_bad_len
      $error("LINE_MAX must be a power of two of at least 4");
   end
   if (NLINE < 4 || (NLINE % 4) != 0) begin : g_bad_lines
      $error("NLINE must be a multiple of 4");
   end
   if (DLY_W < 2) begin : g_bad_dly
      $error("DLY_W must be at least 2");
   end
   if (PIX_W < 1) begin : g_bad_pix
      $error("PIX_W must be positive");
   end

   ldly_cfg_t        cfg;
   logic             mode_eight, mode_wide, b_out, chain;
   logic [LEN_W-1:0] mode_max, eff_len;
   logic [PTR_W-1:0] ptr;
   logic [TAP_W-1:0] src_a, src_b;

   assign cfg        = ldly_cfg_t'(cfg_i);
   assign mode_eight = eight_active(cfg);
   assign mode_wide  = cfg.wide;
   assign b_out      = port_b_active(cfg);
   assign chain      = cfg.chained | mode_wide | b_out;

   assign mode_max = (mode_eight | mode_wide) ? LEN_W'(BANK_DEPTH) : LEN_W'(LINE_MAX);
   assign eff_len  = (len_i == '0 || len_i > mode_max) ? mode_max : len_i;

   assign src_a = mode_wide ? {pix_a_i, pix_b_i} : {{PIX_W{1'b0}}, pix_a_i};
   assign src_b = {{PIX_W{1'b0}}, pix_b_i};

   ldly_addr_gen #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_i    (lres_i),
      .eff_len_i (eff_len),
      .ptr_o     (ptr)
   );

   ldly_rst_delay #(.DLY_W(DLY_W)) u_rdly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lres_i),
      .dly_i (dly_i),
      .q_o   (lres_dly_o)
   );

   logic [PIX_W-1:0] rd      [NLINE];
   logic [PIX_W-1:0] wd      [NLINE];
   logic [NLINE-1:0] we;
   logic [TAP_W-1:0] tap_w   [NLINE];
   logic [TAP_W-1:0] line_in [NLINE];

   // memory banks and their write steering
   for (genvar b = 0; b < NLINE; b++) begin : g_bank
      localparam int  LN  = b / 2;
      localparam bit  ODD = (b % 2) == 1;

      always_comb begin
         if (mode_eight) begin
            we[b] = ~lres_i;
            wd[b] = line_in[b][PIX_W-1:0];
         end else if (mode_wide) begin
            we[b] = ~lres_i;
            wd[b] = ODD ? line_in[LN][PIX_W-1:0] : line_in[LN][TAP_W-1:PIX_W];
         end else begin
            we[b] = ~lres_i & (ptr[PTR_W-1] == ODD);
            wd[b] = line_in[LN][PIX_W-1:0];
         end
      end

      ldly_bank #(.DEPTH(BANK_DEPTH), .W(PIX_W)) u_bank (
         .clk     (clk),
         .we_i    (we[b]),
         .addr_i  (ptr[BAW-1:0]),
         .wdata_i (wd[b]),
         .rdata_o (rd[b])
      );
   end

   // stage outputs assembled from the banks
   for (genvar l = 0; l < NLINE; l++) begin : g_tap
      logic [TAP_W-1:0] raw;
      logic             active;

      if (l < NHALF) begin : g_long
         always_comb begin
            if (mode_eight)
               raw = {{PIX_W{1'b0}}, rd[l]};
            else if (mode_wide)
               raw = {rd[2*l], rd[2*l+1]};
            else
               raw = {{PIX_W{1'b0}}, (ptr[PTR_W-1] ? rd[2*l+1] : rd[2*l])};
         end
         assign active = 1'b1;
      end else begin : g_short
         assign raw    = mode_eight ? {{PIX_W{1'b0}}, rd[l]} : '0;
         assign active = mode_eight;
      end

      if (l == 0) begin : g_first
         assign tap_w[l] = bypass_i ? src_a : raw;
      end else begin : g_rest
         assign tap_w[l] = raw;
      end

      assign taps_o[l*TAP_W +: TAP_W] = active ? tap_w[l] : '0;
   end

   // stage inputs: chain inside a group, group B head selectable
   for (genvar l = 0; l < NLINE; l++) begin : g_in
      localparam bit HEAD4 = (l == NHALF / 2);
      localparam bit HEAD8 = (l == NHALF);
      if (l == 0) begin : g_a_head
         assign line_in[l] = src_a;
      end else begin : g_follow
         logic is_head;
         assign is_head    = mode_eight ? HEAD8 : HEAD4;
         assign line_in[l] = (is_head && !chain) ? src_b : tap_w[l-1];
      end
   end

   assign pix_b_oe = b_out;
   assign pix_b_o  = b_out ? (mode_eight ? tap_w[NLINE-1][PIX_W-1:0]
                                         : tap_w[NHALF-1][PIX_W-1:0])
                           : '0;
endmodule

// File: rtl/ldly_store_chk.sv
module ldly_store_chk #(
   parameter int PTR_W  = 6,
   parameter int LEN_W  = 7,
   parameter int TAPS_W = 128,
   parameter int TAP_W  = 16,
   parameter int DLY_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lres_i,
   input logic [3:0]        cfg_i,
   input logic [LEN_W-1:0]  len_i,
   input logic [DLY_W-1:0]  dly_i,
   input logic [PTR_W-1:0]  ptr,
   input logic [LEN_W-1:0]  eff_len,
   input logic [TAPS_W-1:0] taps_o,
   input logic              lres_dly_o
);
   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           warm <= '0;
      else if (warm != 2'd3) warm <= warm + 1'b1;
   end

   // R7: line reset forces the pointer to zero on the next edge
   p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lres_i |=> (ptr == '0));

   // R1: pointer steps by one below the wrap point
   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!lres_i && (({1'b0, ptr} + 1'b1) < eff_len)) |=> (ptr == $past(ptr) + 1'b1));

   // R1: pointer returns to zero after the last address
   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!lres_i && (({1'b0, ptr} + 1'b1) == eff_len)) |=> (ptr == '0));

   // R7: stored taps are frozen while line reset stays high
   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2 && $past(lres_i) && $past(lres_i, 2) && $stable(cfg_i) && $stable(len_i))
      |-> $stable(taps_o[TAPS_W-1:TAP_W]));

   // R8: with a one-clock setting, the copy trails the input by one edge
   p_dly_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (warm != 2'd0 && dly_i == DLY_W'(1) && $past(dly_i) == DLY_W'(1))
      |-> (lres_dly_o == $past(lres_i)));
endmodule

bind ldly_store ldly_store_chk #(
   .PTR_W  (PTR_W),
   .LEN_W  (LEN_W),
   .TAPS_W (NLINE * TAP_W),
   .TAP_W  (TAP_W),
   .DLY_W  (DLY_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lres_i     (lres_i),
   .cfg_i      (cfg_i),
   .len_i      (len_i),
   .dly_i      (dly_i),
   .ptr        (ptr),
   .eff_len    (eff_len),
   .taps_o     (taps_o),
   .lres_dly_o (lres_dly_o)
);

// File: tb/ldly_store_tb_top.sv
module ldly_store_tb_top;
   localparam int PIX_W    = 8;
   localparam int LINE_MAX = 64;
   localparam int NLINE    = 8;
   localparam int DLY_W    = 6;
   localparam int LEN_W    = $clog2(LINE_MAX) + 1;
   localparam int TAP_W    = 2 * PIX_W;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic [3:0]             cfg_i;
   logic [LEN_W-1:0]       len_i;
   logic [DLY_W-1:0]       dly_i;
   logic                   bypass_i, lres_i;
   logic [PIX_W-1:0]       pix_a_i, pix_b_i;
   logic [NLINE*TAP_W-1:0] taps_o;
   logic [PIX_W-1:0]       pix_b_o;
   logic                   pix_b_oe, lres_dly_o;

   always #10 clk = ~clk;   // 50 MHz

   ldly_store #(.PIX_W(PIX_W), .LINE_MAX(LINE_MAX), .NLINE(NLINE), .DLY_W(DLY_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .len_i(len_i), .dly_i(dly_i),
      .bypass_i(bypass_i), .lres_i(lres_i), .pix_a_i(pix_a_i), .pix_b_i(pix_b_i),
      .taps_o(taps_o), .pix_b_o(pix_b_o), .pix_b_oe(pix_b_oe), .lres_dly_o(lres_dly_o)
   );

   typedef struct {
      int          due;
      int          idx;    // >=0 tap, -1 reset copy, -2 port B output
      logic [15:0] val;
      string       tag;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc++;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   function automatic logic [15:0] observe(input int idx);
      if (idx >= 0)       return taps_o[idx*TAP_W +: TAP_W];
      else if (idx == -1) return {15'd0, lres_dly_o};
      else                return {8'd0, pix_b_o};
   endfunction

   // monitor: compare every queued item in the cycle it is due
   initial begin
      forever begin
         @(negedge clk);
         #2;
         for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
               check(sb[i].tag, observe(sb[i].idx), sb[i].val);
               sb.delete(i);
            end
         end
      end
   end

   task automatic push(input int due, input int idx, input logic [15:0] val, input string tag);
      item_t it;
      it.due = due; it.idx = idx; it.val = val; it.tag = tag;
      sb.push_back(it);
   endtask

   // driver: one mode phase, line reset for 5 cycles then a pixel stream
   task automatic run_phase(input int ph, input logic [3:0] c, input int len,
                            input bit byp, input int dly, input string tag);
      bit eight, wide, lo, sep;
      int nact, half, mmax, L, stream, last_cyc;
      logic [NLINE*TAP_W-1:TAP_W] snap;
      eight  = c[0] && !c[1];
      wide   = c[1];
      lo     = c[3] && !wide;
      sep    = !c[2] && !wide && !lo;
      nact   = eight ? 8 : 4;
      half   = nact / 2;
      mmax   = (eight || wide) ? LINE_MAX / 2 : LINE_MAX;
      L      = (len == 0 || len > mmax) ? mmax : len;
      stream = (nact + 1) * L + 6;
      snap   = '0;
      for (int j = 0; j < 5; j++) begin
         @(negedge clk);
         if (j == 0) last_cyc = cyc + 5 + stream - 1;
         cfg_i = c; len_i = LEN_W'(len); bypass_i = byp; dly_i = DLY_W'(dly);
         lres_i  = 1'b1;
         pix_a_i = 8'(cyc * 7 + ph * 29 + 3);
         pix_b_i = 8'(cyc * 13 + ph * 5 + 1);
         if (cyc + dly <= last_cyc) push(cyc + dly, -1, 16'd1, "R8");
         #2;
         if (j == 1) snap = taps_o[NLINE*TAP_W-1:TAP_W];
         else if (j > 1) begin
            n_chk++;
            if (taps_o[NLINE*TAP_W-1:TAP_W] !== snap) begin
               n_bad++;
               $display("FAIL R7 frozen taps at cycle %0d: actual %h expected %h",
                        cyc, taps_o[NLINE*TAP_W-1:TAP_W], snap);
            end
         end
      end
      for (int s = 0; s < stream; s++) begin
         logic [15:0] va, vb;
         @(negedge clk);
         lres_i  = 1'b0;
         pix_a_i = 8'(cyc * 7 + ph * 29 + 3);
         pix_b_i = 8'(cyc * 13 + ph * 5 + 1);
         va = wide ? {pix_a_i, pix_b_i} : {8'd0, pix_a_i};
         vb = {8'd0, pix_b_i};
         if (cyc + dly <= last_cyc) push(cyc + dly, -1, 16'd0, "R8");
         for (int k = 0; k < nact; k++) begin
            int d;
            logic [15:0] v;
            if (sep && k >= half) begin d = (k - half + 1) * L; v = vb; end
            else begin d = byp ? k * L : (k + 1) * L; v = va; end
            if (cyc + d <= last_cyc) begin
               push(cyc + d, k, v, tag);
               if (lo && k == nact - 1) push(cyc + d, -2, {8'd0, v[7:0]}, "R9");
            end
         end
         if (s == stream / 2) begin
            #2;
            if (!eight) check("R3 idle taps", taps_o[NLINE*TAP_W-1:4*TAP_W] == '0, 16'd1);
            check("R9 port B enable", {15'd0, pix_b_oe}, {15'd0, lo});
            if (!lo) check("R9 port B idle", {8'd0, pix_b_o}, 16'd0);
         end
      end
   endtask

   initial begin
      rst_n = 1'b0; cfg_i = '0; len_i = '0; dly_i = '0; bypass_i = 1'b0;
      lres_i = 1'b0; pix_a_i = '0; pix_b_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      check("R8 reset copy after reset", {15'd0, lres_dly_o}, 16'd0);
      check("R9 port B enable after reset", {15'd0, pix_b_oe}, 16'd0);
      check("R9 port B data after reset", {8'd0, pix_b_o}, 16'd0);

      run_phase(1, 4'b0100, 5,   1'b0, 3, "R1");   // four lines chained
      run_phase(2, 4'b0000, 7,   1'b0, 0, "R5");   // four lines, groups separate
      run_phase(3, 4'b0101, 4,   1'b1, 1, "R6");   // eight lines, bypass
      run_phase(4, 4'b1001, 3,   1'b0, 5, "R9");   // eight lines, last stage on port B
      run_phase(5, 4'b1011, 6,   1'b0, 2, "R10");  // 16-bit pixels, bits 0 and 3 ignored
      run_phase(6, 4'b0100, 0,   1'b0, 4, "R2");   // zero length: full maximum
      run_phase(7, 4'b0101, 100, 1'b0, 1, "R4");   // eight lines, over-range length
      run_phase(8, 4'b1000, 9,   1'b1, 0, "R9");   // four lines, port B out, bypass

      repeat (3) @(negedge clk);
      check("queue drained", 16'(sb.size()), 16'd0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule